// File: doc/BRIEF.md
# Floating-Point Result Normalizer and Rounder

This block turns a raw arithmetic result into a packed single-precision floating word. The raw result is a 72-bit two's-complement fraction, treated as a high word (bits 71:36) and a low word (bits 35:0), together with a signed working exponent and a two-bit storage mode. The block takes the magnitude and remembers the sign. It slides the magnitude until its leading one lands in the target position and adjusts the exponent to match. It then rounds or truncates, fixes up a carry out of the fraction, and inserts the exponent. If the value was negative, it takes the two's complement of the whole packed word.

The packed word is 36 bits: bit 35 is the sign, bits 34:27 hold the exponent field and bits 26:0 hold the fraction. A normalized positive result has bit 26 set. A caller pulses `start` with the operands while `busy` is low. A few cycles later the block raises `done` for one cycle with `result` and the exponent range flags valid. The latency depends on how far the leading one has to travel.

Top module: `float_norm_round`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `result`, `exp_ovf` and `exp_unf` are all zero.
- R2: A raw value of zero gives an all-zero result word and neither range flag is set.
- R3: For any nonzero raw value, the magnitude is normalized so that the fraction field (bits 26:0) has bit 26 set. The 27 fraction bits are the magnitude's leading one and the 26 bits below it.
- R4: The exponent field equals `exp_in + (p - 62)`, where p is the bit index of the magnitude's leading one in the 72-bit value (index 71 is the MSB). This applies before any carry correction. It covers leading ones above bit 62, at bits 61, 60 and 59, further down in the high word, and in the low word only.
- R5: When raw bit 71 is set, the value is negative. The result is the two's complement of the packed positive word built from its magnitude. The most negative raw value is handled as a magnitude of 2^71.
- R6: With `mode_in` = 2'b00 (round), the magnitude bit just below the kept fraction is added into the fraction.
- R7: If rounding or a truncation adjustment carries the fraction to 2^27, the fraction becomes 2^26 and the exponent field increases by one.
- R8: With `mode_in` = 2'b01 (truncate) and a positive value, the bits below the kept fraction are dropped without changing the fraction.
- R9: With truncate and a negative value, the fraction magnitude is raised by one when any discarded magnitude bit is nonzero, so that the negated word equals the two's-complement truncation. When every discarded bit is zero, the fraction is unchanged.
- R10: `mode_in` = 2'b10 (long) and 2'b11 both produce exactly the truncate result.
- R11: When the final exponent exceeds 255, `exp_ovf` is set. When it is below 0, `exp_unf` is set. In both cases the exponent field holds the low 8 bits of the exponent.
- R12: Each `start` accepted while idle yields exactly one single-cycle `done` pulse. A `start` seen while `busy` is high is ignored. `result` changes only in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion; accepted only while idle |
| raw_in | input | 72 | Two's-complement raw fraction, high word in bits 71:36 |
| exp_in | input | 12 | Signed working exponent |
| mode_in | input | 2 | 00 round, 01 truncate, 10 long (truncate), 11 treated as truncate |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 36 | Packed word: sign 35, exponent 34:27, fraction 26:0 |
| exp_ovf | output | 1 | Final exponent was above 255 |
| exp_unf | output | 1 | Final exponent was below zero |

## Verification
The leading one is placed in every normalization class: above the target, exactly on it, one, two and three places below, deep in the high word, and only in the low word. Each placement tells apart a distinct shift step and its exponent correction. Each rounding mode is tried with the same magnitudes of both signs, with and without nonzero discarded bits. This separates round from truncate, and sign-aware truncation from plain truncation. All-ones fractions force the carry correction. Extreme exponents, the most negative input and a start pulse sent during a busy conversion cover the edges. A stream of pseudo-random raw values mixes all of these.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
    parameter int EXP_W    = 8;
    parameter int FRAC_W   = 27;
    parameter int WORD_W   = 1 + EXP_W + FRAC_W;
    parameter int RAW_W    = 2 * WORD_W;
    parameter int WEXP_W   = EXP_W + 4;
    parameter int BIG_STEP = 10;
    // bit index in the 72-bit magnitude where a normalized leading one sits
    parameter int TGT      = RAW_W - 2 - EXP_W;

    typedef logic [RAW_W-1:0]         mag_t;
    typedef logic [WORD_W-1:0]        word_t;
    typedef logic signed [WEXP_W-1:0] wexp_t;

    typedef enum logic [2:0] {
        LC_ZERO, LC_LOW_ONLY, LC_RIGHT, LC_OK, LC_L1, LC_L2, LC_L3, LC_BIG
    } lead_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SIGN, ST_NORM, ST_ROUND, ST_RENORM, ST_PACK
    } state_e;

    typedef enum logic [1:0] {
        MD_ROUND = 2'b00, MD_TRUNC = 2'b01, MD_LONG = 2'b10, MD_SPARE = 2'b11
    } mode_e;

    function automatic logic mode_truncates(mode_e m);
        return m != MD_ROUND;
    endfunction
endpackage

// File: rtl/nrm_lead_class.sv
module nrm_lead_class
    import nrm_pkg::*;
(
    input  mag_t      mag,
    output lead_cls_e cls
);
    always_comb begin
        if (mag[RAW_W-1:WORD_W] == '0)
            cls = (mag[WORD_W-1:0] == '0) ? LC_ZERO : LC_LOW_ONLY;
        else if (mag[RAW_W-1:TGT+1] != '0)
            cls = LC_RIGHT;
        else if (mag[TGT])
            cls = LC_OK;
        else if (mag[TGT-1])
            cls = LC_L1;
        else if (mag[TGT-2])
            cls = LC_L2;
        else if (mag[TGT-3])
            cls = LC_L3;
        else
            cls = LC_BIG;
    end
endmodule

// File: rtl/nrm_round_unit.sv
module nrm_round_unit
    import nrm_pkg::*;
(
    input  mag_t  mag,
    input  logic  sticky,
    input  mode_e mode,
    input  logic  neg,
    output word_t hi_out
);
    logic disc_nz;
    logic inc;

    always_comb begin
        disc_nz = (mag[WORD_W-1:0] != '0) | sticky;
        inc     = mode_truncates(mode) ? (neg & disc_nz) : mag[WORD_W-1];
        hi_out  = mag[RAW_W-1:WORD_W] + word_t'(inc);
    end
endmodule

// File: rtl/nrm_pack_unit.sv
module nrm_pack_unit
    import nrm_pkg::*;
(
    input  word_t hi,
    input  wexp_t e,
    input  logic  neg,
    input  logic  zero,
    output word_t word,
    output logic  ovf,
    output logic  unf
);
    localparam wexp_t EMAX = wexp_t'((1 << EXP_W) - 1);
    word_t pos_w;

    always_comb begin
        pos_w = {1'b0, e[EXP_W-1:0], hi[FRAC_W-1:0]};
        if (zero)
            word = '0;
        else if (neg)
            word = -pos_w;
        else
            word = pos_w;
        ovf = !zero && (e > EMAX);
        unf = !zero && (e < 0);
    end
endmodule

// File: rtl/float_norm_round.sv
module float_norm_round
    import nrm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [RAW_W-1:0]         raw_in,
    input  logic signed [WEXP_W-1:0] exp_in,
    input  logic [1:0]               mode_in,
    output logic                     busy,
    output logic                     done,
    output logic [WORD_W-1:0]        result,
    output logic                     exp_ovf,
    output logic                     exp_unf
);
    localparam wexp_t E_ONE  = wexp_t'(1);
    localparam wexp_t E_TWO  = wexp_t'(2);
    localparam wexp_t E_THR  = wexp_t'(3);
    localparam wexp_t E_BIG  = wexp_t'(BIG_STEP);
    localparam wexp_t E_WORD = wexp_t'(WORD_W);

    state_e    st;
    mag_t      m;
    wexp_t     e;
    mode_e     md;
    logic      neg, sticky, zero;
    lead_cls_e cls;
    word_t     rnd_hi;
    word_t     pk_word;
    logic      pk_ovf, pk_unf;

    nrm_lead_class u_cls (.mag(m), .cls(cls));

    nrm_round_unit u_rnd (
        .mag(m), .sticky(sticky), .mode(md), .neg(neg), .hi_out(rnd_hi)
    );

    nrm_pack_unit u_pack (
        .hi(m[RAW_W-1:WORD_W]), .e(e), .neg(neg), .zero(zero),
        .word(pk_word), .ovf(pk_ovf), .unf(pk_unf)
    );

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            m       <= '0;
            e       <= '0;
            md      <= MD_ROUND;
            neg     <= 1'b0;
            sticky  <= 1'b0;
            zero    <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
            exp_ovf <= 1'b0;
            exp_unf <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    m      <= raw_in;
                    e      <= exp_in;
                    md     <= mode_e'(mode_in);
                    neg    <= 1'b0;
                    sticky <= 1'b0;
                    zero   <= 1'b0;
                    st     <= ST_SIGN;
                end
                ST_SIGN: begin
                    if (m[RAW_W-1]) begin
                        m   <= -m;
                        neg <= 1'b1;
                    end
                    st <= ST_NORM;
                end
                ST_NORM: begin
                    case (cls)
                        LC_ZERO: begin
                            zero <= 1'b1;
                            st   <= ST_PACK;
                        end
                        LC_LOW_ONLY: begin
                            m <= m << WORD_W;
                            e <= e - E_WORD;
                        end
                        LC_RIGHT: begin
                            m      <= m >> 2;
                            sticky <= sticky | (m[1:0] != '0);
                            e      <= e + E_TWO;
                        end
                        LC_OK: st <= ST_ROUND;
                        LC_L1: begin
                            m  <= m << 1;
                            e  <= e - E_ONE;
                            st <= ST_ROUND;
                        end
                        LC_L2: begin
                            m  <= m << 2;
                            e  <= e - E_TWO;
                            st <= ST_ROUND;
                        end
                        LC_L3: begin
                            m  <= m << 3;
                            e  <= e - E_THR;
                            st <= ST_ROUND;
                        end
                        default: begin
                            m <= m << BIG_STEP;
                            e <= e - E_BIG;
                        end
                    endcase
                end
                ST_ROUND: begin
                    m  <= {rnd_hi, {WORD_W{1'b0}}};
                    st <= ST_RENORM;
                end
                ST_RENORM: begin
                    if (m[TGT+1]) begin
                        m <= m >> 1;
                        e <= e + E_ONE;
                    end
                    st <= ST_PACK;
                end
                ST_PACK: begin
                    result  <= pk_word;
                    exp_ovf <= pk_ovf;
                    exp_unf <= pk_unf;
                    done    <= 1'b1;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nrm_chk.sv
module nrm_chk
    import nrm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [WORD_W-1:0] result,
    input logic        exp_ovf,
    input logic        exp_unf
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy) && !busy); // R12

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)); // R12

    AST_NORM_LEAD: assert property (@(posedge clk) disable iff (rst)
        (done && !result[WORD_W-1] && result != '0) |-> result[FRAC_W-1]); // R3

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        done |-> !(exp_ovf && exp_unf)); // R11

    AST_ZERO_NOFLAG: assert property (@(posedge clk) disable iff (rst)
        (done && result == '0) |-> (!exp_ovf && !exp_unf)); // R2
endmodule

bind float_norm_round nrm_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .result(result), .exp_ovf(exp_ovf), .exp_unf(exp_unf)
);

// File: tb/sim_float_norm_round.sv
`timescale 1ns/1ps
module sim_float_norm_round;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [71:0]        raw_in = '0;
    logic signed [11:0] exp_in = '0;
    logic [1:0]         mode_in = '0;
    logic               busy, done, exp_ovf, exp_unf;
    logic [35:0]        result;

    typedef struct {
        logic [35:0] w;
        logic        o;
        logic        u;
        string       tag;
    } exp_item_t;

    exp_item_t sb[$];
    int checks = 0;
    int fails  = 0;
    int pushed = 0;
    int seen   = 0;

    always #2.5 clk = ~clk;

    float_norm_round u0 (
        .clk(clk), .rst(rst), .start(start), .raw_in(raw_in), .exp_in(exp_in),
        .mode_in(mode_in), .busy(busy), .done(done), .result(result),
        .exp_ovf(exp_ovf), .exp_unf(exp_unf)
    );

    function automatic logic [35:0] model(input logic [71:0] raw,
                                          input logic signed [11:0] ex,
                                          input logic [1:0] md,
                                          output logic ovf, output logic unf);
        logic [71:0] mag, sh, mask;
        logic [27:0] k;
        logic [35:0] w;
        logic        neg, disc_nz, rb, inc;
        int          p, e;
        neg = raw[71];
        mag = neg ? (~raw + 72'd1) : raw;
        ovf = 1'b0;
        unf = 1'b0;
        if (mag == '0) return '0;
        p = 0;
        for (int i = 0; i < 72; i++) if (mag[i]) p = i;
        if (p >= 26) sh = mag >> (p - 26);
        else         sh = mag << (26 - p);
        k = {1'b0, sh[26:0]};
        disc_nz = 1'b0;
        rb = 1'b0;
        if (p > 26) begin
            mask = (72'd1 << (p - 26)) - 72'd1;
            disc_nz = (mag & mask) != '0;
            rb = mag[p-27];
        end
        e = int'(ex) + p - 62;
        inc = (md == 2'b00) ? rb : (neg & disc_nz);
        k = k + {27'd0, inc};
        if (k[27]) begin
            k = k >> 1;
            e = e + 1;
        end
        ovf = e > 255;
        unf = e < 0;
        w = {1'b0, e[7:0], k[26:0]};
        if (neg) w = -w;
        return w;
    endfunction

    task automatic run_case(input logic [71:0] raw, input logic signed [11:0] ex,
                            input logic [1:0] md, input string tag);
        exp_item_t it;
        logic o, u;
        it.w = model(raw, ex, md, o, u);
        it.o = o;
        it.u = u;
        it.tag = tag;
        sb.push_back(it);
        pushed++;
        @(negedge clk);
        raw_in = raw; exp_in = ex; mode_in = md; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            seen++;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected done: actual result=%h expected none", result);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                if (result !== it.w || exp_ovf !== it.o || exp_unf !== it.u) begin
                    fails++;
                    $display("FAIL %s: actual w=%h ovf=%b unf=%b expected w=%h ovf=%b unf=%b",
                             it.tag, result, exp_ovf, exp_unf, it.w, it.o, it.u);
                end
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [35:0] act,
                       input logic [35:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [71:0] lfsr;
        logic [71:0] ones28;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", {35'd0, busy}, 36'd0);
        chk(done == 1'b0, "R1 done", {35'd0, done}, 36'd0);
        chk(result == '0 && !exp_ovf && !exp_unf, "R1 result", result, 36'd0);
        rst = 1'b0;
        @(negedge clk);

        ones28 = ((72'd1 << 28) - 72'd1) << 35;
        // R3 R4 placement classes
        run_case((72'd1 << 62) | (72'h5A5A5A5 << 36), 12'sd128, 2'b00, "R3 already normalized");
        run_case((72'd1 << 70) | 72'h3_0000_1234, 12'sd128, 2'b00, "R4 right shifts");
        run_case((72'd1 << 61) | 72'hABC, 12'sd128, 2'b01, "R4 left one");
        run_case((72'd1 << 60) | (72'h77 << 30), 12'sd128, 2'b01, "R4 left two");
        run_case((72'd1 << 59) | 72'h5, 12'sd128, 2'b00, "R4 left three");
        run_case((72'd1 << 40) | 72'hF0F, 12'sd128, 2'b00, "R4 deep high word");
        run_case((72'd1 << 20) | 72'h3, 12'sd128, 2'b00, "R4 low word only");
        run_case(72'd0, 12'sd77, 2'b00, "R2 zero");
        // R5 negative values
        run_case(-((72'd1 << 62) | (72'h123 << 36)), 12'sd128, 2'b00, "R5 negative");
        run_case(72'd1 << 71, 12'sd0, 2'b01, "R5 most negative");
        // R6 R7 rounding
        run_case((72'd1 << 62) | (72'd1 << 35) | 72'd7, 12'sd128, 2'b00, "R6 round up");
        run_case(-((72'd1 << 62) | (72'd1 << 35)), 12'sd128, 2'b00, "R6 round negative");
        run_case(ones28, 12'sd128, 2'b00, "R7 round carry");
        // R8 R9 truncation
        run_case((72'd1 << 62) | (72'd1 << 35) | 72'd7, 12'sd128, 2'b01, "R8 truncate positive");
        run_case(-((72'd1 << 62) | (72'd1 << 3)), 12'sd128, 2'b01, "R9 truncate negative sticky");
        run_case(-((72'd1 << 62) | (72'd1 << 40)), 12'sd128, 2'b01, "R9 truncate negative exact");
        run_case(-(ones28 | 72'd1), 12'sd128, 2'b01, "R9 R7 truncate negative carry");
        run_case(-((72'd1 << 70) | 72'd1), 12'sd128, 2'b01, "R9 sticky from right shift");
        // R10 long and spare codes
        run_case(-((72'd1 << 62) | (72'd1 << 3)), 12'sd128, 2'b10, "R10 long mode");
        run_case(-((72'd1 << 62) | (72'd1 << 3)), 12'sd128, 2'b11, "R10 spare mode");
        run_case((72'd1 << 62) | (72'd1 << 35), 12'sd128, 2'b10, "R10 long positive");
        // R11 range flags
        run_case((72'd1 << 70) | 72'd9, 12'sd250, 2'b00, "R11 overflow");
        run_case((72'd1 << 20), 12'sd3, 2'b00, "R11 underflow");
        run_case((72'd1 << 62), 12'sd255, 2'b00, "R11 top exponent no flag");

        // R12 start while busy is ignored
        begin
            exp_item_t it;
            logic o, u;
            it.w = model((72'd1 << 50) | 72'h99, 12'sd100, 2'b00, o, u);
            it.o = o; it.u = u; it.tag = "R12 busy start ignored";
            sb.push_back(it);
            pushed++;
            @(negedge clk);
            raw_in = (72'd1 << 50) | 72'h99; exp_in = 12'sd100; mode_in = 2'b00; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            raw_in = 72'd1 << 5; exp_in = 12'sd7; mode_in = 2'b01; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (busy) @(negedge clk);
            repeat (4) @(negedge clk);
        end

        // mixed pseudo-random stream, R4 R6 R9
        lfsr = 72'hC3A5_1F0E_9D27_6B48_E1;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[70:0], lfsr[71] ^ lfsr[65] ^ lfsr[24] ^ lfsr[18]};
            run_case(lfsr >> (n % 9) * 7, 12'sd120, 2'(n % 4), "R4 R6 R9 random");
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0 && seen == pushed, "R12 one done per accepted start",
            36'(seen), 36'(pushed));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule